// File: doc/BRIEF.md
# Status Register Auto-Polling Matcher

This block watches a device status register without software involvement. Once started, it asks an external command sequencer for a status read. When the sequencer hands back the assembled status word, the block compares the low 1 to 4 bytes of that word against a programmed match value, bit by bit, under a programmed mask. It then waits a programmed number of clock cycles and asks again.

A comparison can be made in one of two ways. AND mode needs every selected bit to agree with the match value. OR mode is satisfied by any single selected bit that agrees. A successful comparison sets a sticky match flag, which software clears with a one-cycle strobe. The block can be told to stop by itself on the first success, or to keep polling until it is aborted or disabled. The most recent status word is always kept for reading, with the bytes beyond the programmed size forced to zero.

The read request is a level signal, `rd_req`. Each one-cycle `rd_done` pulse from the sequencer ends one read. Configuration inputs are sampled live and are expected to stay steady while the block is busy.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset, `busy`, `rd_req` and `match_flag` are 0 and `last_status` is 0.
- R2: A one-cycle `start` while idle, with `enable` high and `abort` low, makes `rd_req` and `busy` high from the next clock edge. While `enable` is low, `start` is ignored.
- R3: In AND mode (`cfg_or_mode`=0), a read matches when every bit selected by `cfg_mask` (1 = compared) equals the same bit of `cfg_match`. An all-zero effective mask always matches.
- R4: In OR mode (`cfg_or_mode`=1), a read matches when at least one selected bit equals its match bit. An all-zero effective mask never matches.
- R5: `cfg_size` encodes the status size as size-1: 0 gives 1 byte (bits 7:0), 1 gives 2 bytes, 2 gives 3 bytes, and 3 gives 4 bytes. Bits above 8×size take no part in the comparison. `last_status` holds the captured word with those upper bits zero, from the edge that sees `rd_done`.
- R6: After a completed read that does not end polling, `rd_req` stays low for exactly `cfg_interval` cycles before the next request. An interval of 0 keeps `rd_req` high back to back.
- R7: With `cfg_auto_stop`=1, a matching read ends polling: `busy` and `rd_req` are low from the edge that captures that read.
- R8: With `cfg_auto_stop`=0, polling continues after a match, and every later matching read sets `match_flag` again.
- R9: An `abort` during a read lets that read complete and be captured, and then the block goes idle without another request. An `abort` during the wait makes the block idle at the next edge.
- R10: `match_flag` is sticky. It is cleared by `flag_clr`, but a matching capture in the same cycle wins, so the flag stays set.
- R11: Dropping `enable` acts as an abort: a read in flight still completes, and a wait ends at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low stops polling |
| start | input | 1 | One-cycle pulse that starts polling |
| abort | input | 1 | One-cycle pulse that stops polling |
| flag_clr | input | 1 | Clear strobe for the match flag |
| cfg_match | input | 32 | Match value |
| cfg_mask | input | 32 | Compare mask, 1 = bit compared |
| cfg_size | input | 2 | Status size in bytes minus one |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_or_mode | input | 1 | 0 = AND match, 1 = OR match |
| cfg_auto_stop | input | 1 | Stop polling on first match |
| rd_req | output | 1 | Status read request, held until `rd_done` |
| rd_done | input | 1 | One-cycle pulse: read finished, `rd_data` valid |
| rd_data | input | 32 | Assembled status word from the sequencer |
| busy | output | 1 | Polling active |
| match_flag | output | 1 | Sticky status-match flag |
| last_status | output | 32 | Latest captured status, size-trimmed |

## Verification
Every result is registered once. `rd_req` and `busy` change on the first edge after `start`, or on the edge that captures `rd_done`. `match_flag` and `last_status` change on the capturing edge itself, and the next request follows exactly `cfg_interval` cycles after that edge. The bench drives all inputs on falling edges and recognises a capture by looking, at the rising edge, for `rd_done` together with `rd_req`. It then samples the outputs at the following falling edge. It measures the gap between reads by counting the falling edges at which `rd_req` is low.

// File: rtl/poll_pkg.sv
// Package: shared widths and the sequencing state type of the polling matcher.
// Assumes: status words are a whole number of bytes.
package poll_pkg;
    localparam int unsigned STAT_W  = 32;
    localparam int unsigned IVL_W   = 16;
    localparam int unsigned BYTES   = STAT_W / 8;
    localparam int unsigned SIZE_W  = $clog2(BYTES);

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_READ = 2'd1,
        PS_GAP  = 2'd2
    } poll_state_t;
endpackage

// File: rtl/poll_compare.sv
// Module: poll_compare
// Combinational comparison of a status word against mask and match value.
// The active width is 1..BYTES bytes, chosen by `size` (size-1 encoding).
// Produces a hit for AND or OR mode, and the byte mask of active bytes.
// Assumes: inputs are stable in the cycle where the hit is consumed.
module poll_compare #(
    parameter int unsigned STAT_W = 32,
    parameter int unsigned SIZE_W = 2
) (
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] match_val,
    input  logic [STAT_W-1:0] mask,
    input  logic [SIZE_W-1:0] size,
    input  logic              or_mode,
    output logic [STAT_W-1:0] size_mask,
    output logic              hit
);
    localparam int unsigned NBYTE = STAT_W / 8;

    logic [STAT_W-1:0] sel_bits;
    logic [STAT_W-1:0] agree_bits;

    // Per byte: a byte takes part when its index does not exceed size.
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign size_mask[b*8 +: 8] = (b <= int'(size)) ? 8'hFF : 8'h00;
    end

    // Select the compared bits and mark the ones that agree with the match value.
    always_comb begin
        sel_bits   = mask & size_mask;
        agree_bits = ~(status ^ match_val) & sel_bits;
    end

    // Mode-dependent reduction of the agreeing bits.
    always_comb begin
        if (or_mode) hit = |agree_bits;
        else         hit = (agree_bits == sel_bits);
    end
endmodule

// File: rtl/poll_gap_timer.sv
// Module: poll_gap_timer
// Down-counter that times the idle gap between two status reads.
// It is loaded when a read completes and counts while the gap is running.
// `expire` marks the last gap cycle. Assumes: a load value of 0 is never
// run, because the controller skips the gap in that case.
module poll_gap_timer #(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IVL_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [IVL_W-1:0] cnt;

    // Counter: reload on completion, decrement while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    // Last gap cycle: the count is down to one.
    assign expire = run && (cnt == IVL_W'(1));

    // R6: the count falls by exactly one per running cycle.
    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt > IVL_W'(1)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/poll_ctrl.sv
// Module: poll_ctrl
// Sequencing of the polling loop: idle, read in flight, gap.
// Decides after each read whether to stop (auto stop on hit, abort or
// disable) or to continue, either back to back or through the gap timer.
// An abort seen during a read is remembered, so that the read can finish.
// Assumes: rd_done is a one-cycle pulse that is only meaningful during a read.
module poll_ctrl
    import poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic abort,
    input  logic rd_done,
    input  logic hit,
    input  logic auto_stop,
    input  logic gap_zero,
    input  logic gap_expire,
    output logic rd_req,
    output logic busy,
    output logic capture,
    output logic gap_load,
    output logic gap_run
);
    poll_state_t state, state_nx;
    logic        abort_pend;
    logic        stop_req;

    // Any reason to end polling after the current read.
    assign stop_req = abort || abort_pend || !enable;
    assign capture  = (state == PS_READ) && rd_done;
    assign gap_load = capture;
    assign gap_run  = (state == PS_GAP);
    assign rd_req   = (state == PS_READ);
    assign busy     = (state != PS_IDLE);

    // Next-state choice for the polling loop.
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: if (start && enable && !abort) state_nx = PS_READ;
            PS_READ: begin
                if (rd_done) begin
                    if ((hit && auto_stop) || stop_req) state_nx = PS_IDLE;
                    else if (gap_zero)                  state_nx = PS_READ;
                    else                                state_nx = PS_GAP;
                end
            end
            PS_GAP: begin
                if (abort || !enable) state_nx = PS_IDLE;
                else if (gap_expire)  state_nx = PS_READ;
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    // Remember an abort raised while a read is still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          abort_pend <= 1'b0;
        else if (state != PS_READ)                           abort_pend <= 1'b0;
        else if (capture)                                    abort_pend <= 1'b0;
        else if (abort)                                      abort_pend <= 1'b1;
    end

    // R2: an accepted start raises the request on the next edge.
    assert_start_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && enable && !abort) |=> rd_req);
    // R7: a hit with auto stop ends polling at the capture edge.
    assert_auto_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && hit && auto_stop) |=> !busy);
    // R9: an abort during the gap ends polling at the next edge.
    assert_gap_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_run && abort) |=> !busy);
    // R11: a disabled block never starts polling from idle.
    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy);
endmodule

// File: rtl/status_poll_matcher.sv
// Module: status_poll_matcher (top)
// Autonomous status poller: it requests status reads from a command sequencer,
// compares each result under mask and match value, keeps a sticky match flag
// and the latest size-trimmed status word, and paces reads with a gap timer.
// Assumes: configuration inputs are held steady while busy.
module status_poll_matcher
    import poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              abort,
    input  logic              flag_clr,
    input  logic [STAT_W-1:0] cfg_match,
    input  logic [STAT_W-1:0] cfg_mask,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic              cfg_or_mode,
    input  logic              cfg_auto_stop,
    output logic              rd_req,
    input  logic              rd_done,
    input  logic [STAT_W-1:0] rd_data,
    output logic              busy,
    output logic              match_flag,
    output logic [STAT_W-1:0] last_status
);
    logic [STAT_W-1:0] size_mask;
    logic              hit;
    logic              capture;
    logic              gap_load;
    logic              gap_run;
    logic              gap_expire;
    logic              flag_set;

    poll_compare #(.STAT_W(STAT_W), .SIZE_W(SIZE_W)) u_cmp (
        .status    (rd_data),
        .match_val (cfg_match),
        .mask      (cfg_mask),
        .size      (cfg_size),
        .or_mode   (cfg_or_mode),
        .size_mask (size_mask),
        .hit       (hit)
    );

    poll_gap_timer #(.IVL_W(IVL_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cfg_interval),
        .run      (gap_run),
        .expire   (gap_expire)
    );

    poll_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start      (start),
        .abort      (abort),
        .rd_done    (rd_done),
        .hit        (hit),
        .auto_stop  (cfg_auto_stop),
        .gap_zero   (cfg_interval == '0),
        .gap_expire (gap_expire),
        .rd_req     (rd_req),
        .busy       (busy),
        .capture    (capture),
        .gap_load   (gap_load),
        .gap_run    (gap_run)
    );

    assign flag_set = capture && hit;

    // Hold the latest status with bytes beyond the programmed size zeroed.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_status <= '0;
        else if (capture) last_status <= rd_data & size_mask;
    end

    // Sticky match flag: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_flag <= 1'b0;
        else if (flag_set) match_flag <= 1'b1;
        else if (flag_clr) match_flag <= 1'b0;
    end

    // R10: a clear with no matching capture empties the flag.
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(rd_done && rd_req && hit)) |=> !match_flag);
    // R10: a matching capture always leaves the flag set.
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_req && hit) |=> match_flag);
    // R5: a one-byte capture leaves the upper status bits at zero.
    assert_size_trim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_req && cfg_size == '0) |=> (last_status[STAT_W-1:8] == '0));
    // R1: no request is ever presented while the block reports idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);
endmodule

// File: tb/test_status_poll_matcher.sv
module test_status_poll_matcher;
    typedef struct packed {
        logic [31:0] match_v;
        logic [31:0] mask_v;
        logic [1:0]  size_v;
        logic        or_v;
        logic [31:0] stat_v;
        logic        exp_hit;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'hA5A5_0001, 32'hFFFF_FFFF, 2'd3, 1'b0, 32'hA5A5_0001, 1'b1}, // R3 full equal
        '{32'hA5A5_0001, 32'hFFFF_FFFF, 2'd3, 1'b0, 32'hA5A5_0003, 1'b0}, // R3 one bit off
        '{32'hA5A5_0001, 32'hFFFF_FFFD, 2'd3, 1'b0, 32'hA5A5_0003, 1'b1}, // R3 bit masked out
        '{32'h0000_000F, 32'h0000_000F, 2'd0, 1'b1, 32'h0000_00F8, 1'b1}, // R4 one bit agrees
        '{32'h0000_00F0, 32'h0000_00F0, 2'd0, 1'b1, 32'h0000_000F, 1'b0}, // R4 none agree
        '{32'hFFFF_FF5A, 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h0000_005A, 1'b1}, // R5 upper ignored
        '{32'h0000_1234, 32'h0000_FFFF, 2'd1, 1'b0, 32'hAB12_1234, 1'b1}, // R5 two bytes
        '{32'h0056_0000, 32'h00FF_0000, 2'd2, 1'b0, 32'h0057_0000, 1'b0}, // R5 byte 2 differs
        '{32'h1234_5678, 32'h0000_0000, 2'd3, 1'b1, 32'h1234_5678, 1'b0}, // R4 empty mask
        '{32'h1234_5678, 32'h0000_0000, 2'd3, 1'b0, 32'h0000_0000, 1'b1}  // R3 empty mask
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] cfg_match = '0;
    logic [31:0] cfg_mask = '0;
    logic [1:0]  cfg_size = '0;
    logic [15:0] cfg_interval = '0;
    logic        cfg_or_mode = 1'b0;
    logic        cfg_auto_stop = 1'b0;
    logic        rd_req;
    logic        rd_done = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy;
    logic        match_flag;
    logic [31:0] last_status;

    int vectors = 0;
    int miscompares = 0;
    int n_reads = 0;
    int lat = 0;

    always #5 clk = ~clk;

    status_poll_matcher i_status_poll_matcher (
        .clk, .rst_n, .enable, .start, .abort, .flag_clr,
        .cfg_match, .cfg_mask, .cfg_size, .cfg_interval,
        .cfg_or_mode, .cfg_auto_stop,
        .rd_req, .rd_done, .rd_data,
        .busy, .match_flag, .last_status
    );

    // Sequencer model: answers a held request after two cycles with a one-cycle done.
    always @(negedge clk) begin
        if (rd_done) begin
            rd_done <= 1'b0;
            lat     <= 0;
        end else if (rd_req) begin
            if (lat == 2) begin
                rd_done <= 1'b1;
                n_reads <= n_reads + 1;
                lat     <= 0;
            end else lat <= lat + 1;
        end else lat <= 0;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] trim(input logic [1:0] sz);
        trim = '0;
        for (int b = 0; b < 4; b++) if (b <= int'(sz)) trim[b*8 +: 8] = 8'hFF;
    endfunction

    // Waits for the rising edge that captures a read, then the next falling edge.
    task automatic wait_capture();
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            if (rd_done && rd_req) break;
        end
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic stop_poll();
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic measure_gap(output int gap);
        gap = 0;
        for (int i = 0; i < 200; i++) begin
            if (rd_req) break;
            gap++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int gap;
        int reads0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !rd_req, "R1 idle after reset", {30'd0, busy, rd_req}, 32'd0);
        chk(!match_flag, "R1 flag after reset", {31'd0, match_flag}, 32'd0);
        chk(last_status == 0, "R1 status after reset", last_status, 32'd0);

        // Table walk: R3 R4 R5 comparison and capture
        cfg_auto_stop = 1'b0;
        cfg_interval  = 16'd3;
        for (int v = 0; v < NV; v++) begin
            cfg_match = VECS[v].match_v; cfg_mask = VECS[v].mask_v;
            cfg_size = VECS[v].size_v; cfg_or_mode = VECS[v].or_v;
            rd_data = VECS[v].stat_v;
            flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
            pulse_start();
            wait_capture();
            chk(match_flag == VECS[v].exp_hit, VECS[v].or_v ? "R4 match result" : "R3 match result",
                {31'd0, match_flag}, {31'd0, VECS[v].exp_hit});
            chk(last_status == (VECS[v].stat_v & trim(VECS[v].size_v)), "R5 captured status",
                last_status, VECS[v].stat_v & trim(VECS[v].size_v));
            // R9 abort during the gap: idle at the next edge
            abort = 1'b1; @(negedge clk); abort = 1'b0;
            chk(!busy, "R9 abort in gap", {31'd0, busy}, 32'd0);
        end

        // R2 start raises the request one edge later
        cfg_match = 32'h0; cfg_mask = 32'hFF; cfg_size = 2'd0; cfg_or_mode = 1'b0;
        rd_data = 32'h1; cfg_interval = 16'd5; cfg_auto_stop = 1'b0;
        pulse_start();
        chk(rd_req && busy, "R2 request after start", {30'd0, rd_req, busy}, 32'd3);
        // R6 gap of five cycles
        wait_capture();
        measure_gap(gap);
        chk(gap == 5, "R6 gap length 5", gap, 32'd5);
        stop_poll();
        // R6 zero interval keeps the request high
        cfg_interval = 16'd0;
        pulse_start();
        wait_capture();
        chk(rd_req, "R6 back to back request", {31'd0, rd_req}, 32'd1);
        wait_capture();
        chk(rd_req && n_reads > 1, "R6 second back to back read", {31'd0, rd_req}, 32'd1);
        stop_poll();

        // R7 auto stop on match
        rd_data = 32'h0; cfg_interval = 16'd2; cfg_auto_stop = 1'b1;
        pulse_start();
        wait_capture();
        chk(!busy && match_flag, "R7 stopped on match", {30'd0, busy, match_flag}, 32'd1);
        reads0 = n_reads;
        repeat (10) @(negedge clk);
        chk(n_reads == reads0 && !rd_req, "R7 no further reads", n_reads, reads0);

        // R8 continue after match; flag sets again after a clear
        cfg_auto_stop = 1'b0;
        pulse_start();
        wait_capture();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk(!match_flag, "R10 flag cleared", {31'd0, match_flag}, 32'd0);
        chk(busy, "R8 still polling after match", {31'd0, busy}, 32'd1);
        wait_capture();
        chk(match_flag, "R8 flag set again", {31'd0, match_flag}, 32'd1);
        stop_poll();

        // R10 set wins over a clear held across the capture
        cfg_auto_stop = 1'b1;
        flag_clr = 1'b1;
        pulse_start();
        wait_capture();
        chk(match_flag, "R10 set wins over clear", {31'd0, match_flag}, 32'd1);
        @(negedge clk);
        chk(!match_flag, "R10 clear afterwards", {31'd0, match_flag}, 32'd0);
        flag_clr = 1'b0;

        // R9 abort during a read: read completes, then idle
        cfg_auto_stop = 1'b0; rd_data = 32'h77;
        reads0 = n_reads;
        pulse_start();
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk(busy && rd_req, "R9 read continues after abort", {30'd0, busy, rd_req}, 32'd3);
        wait_capture();
        chk(!busy && last_status == 32'h77, "R9 idle after read", last_status, 32'h77);
        repeat (8) @(negedge clk);
        chk(n_reads == reads0 + 1 && !rd_req, "R9 no extra read", n_reads, reads0 + 1);

        // R11 start ignored while disabled
        enable = 1'b0;
        pulse_start();
        @(negedge clk);
        chk(!busy && !rd_req, "R11 start ignored when disabled", {30'd0, busy, rd_req}, 32'd0);
        // R11 disable during the gap ends polling
        enable = 1'b1; cfg_interval = 16'd6;
        pulse_start();
        wait_capture();
        enable = 1'b0; @(negedge clk);
        chk(!busy, "R11 disable in gap", {31'd0, busy}, 32'd0);
        enable = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule